// File: doc/BRIEF.md
# Software-Pipelined Loop Branch Controller

This block makes the decision for the branch that closes a loop. It keeps two down-counters: an iteration count and a drain count. A plain counted branch looks only at the iteration count. It is taken while that count is nonzero and lowers the count by one each time it is taken. A pipelined-loop branch uses both counters. While iterations remain, it lowers the iteration count, feeds a 1 into the first-stage predicate, requests a rotation and is taken. Once the iterations have run out, the drain count keeps the branch taken while zeros flow into the first stage, so that the later stages of the software pipeline can empty.

The decision is combinational. `taken`, `rotate` and `stage1_pred` are valid in the same cycle as the `br_strobe` pulse, and the counters update at the next rising edge. A counter load in the same cycle as a strobe takes priority, and the branch sees the loaded value. All pins are plain control pins. Nothing streams through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `loop_branch_ctrl`

## Requirements
- R1: After reset both counters are zero, so a pipelined-loop branch (`br_kind`=1) gives taken=0, rotate=0 and stage1_pred=0.
- R2: A counted branch (`br_kind`=0) with a nonzero iteration count gives taken=1 and rotate=0, and lowers the iteration count by one.
- R3: A counted branch with an iteration count of zero gives taken=0 and leaves the count at zero.
- R4: A pipelined-loop branch with a nonzero iteration count gives taken=1, rotate=1 and stage1_pred=1. It lowers the iteration count by one and leaves the drain count unchanged.
- R5: A pipelined-loop branch with an iteration count of zero and a drain count above 1 gives taken=1, rotate=1 and stage1_pred=0, and lowers the drain count by one.
- R6: A pipelined-loop branch with an iteration count of zero and a drain count of 1 gives taken=0, rotate=1 and stage1_pred=0, and sets the drain count to zero.
- R7: A pipelined-loop branch with both counts zero gives taken=0, rotate=0 and stage1_pred=0, and changes nothing.
- R8: A load in the same cycle as a strobe takes priority, and that branch is decided on the loaded value.
- R9: With an iteration count of 127 and a drain count of 4, pipelined-loop branches are taken exactly 130 times in a row and then fall through once, with 131 rotations in total.
- R10: When `br_strobe` is low, taken, rotate and stage1_pred are 0 and the counters hold their values unless a load is applied.
- R11: A counted branch never changes the drain count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| br_strobe | input | 1 | A loop-closing branch executes in this cycle |
| br_kind | input | 1 | 0 = counted branch, 1 = pipelined-loop branch |
| iter_load | input | 1 | Load the iteration count |
| iter_value | input | CNT_W | Value for the iteration count |
| drain_load | input | 1 | Load the drain count |
| drain_value | input | DRN_W | Value for the drain count |
| taken | output | 1 | The branch returns to the loop head |
| rotate | output | 1 | Rotate the registers and predicates at the end of this iteration |
| stage1_pred | output | 1 | Value fed into the first-stage predicate |

## Verification
The counters are not visible at the ports, so a wrong count shows up only in later branches. An iteration count that is off by one moves the point where stage1_pred changes from 1 to 0. A wrong drain count shifts the cycle in which the fall-through arrives. In the long run, either error shows as a taken total other than 130. A counted branch that disturbed the drain count would cost or add a drain iteration in the next pipelined loop. A decrement that runs past zero would keep the branch taken long after it should have fallen through.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  typedef enum logic {
    BR_COUNTED = 1'b0,
    BR_PIPELINED = 1'b1
  } br_kind_t;
endpackage

// File: rtl/lbc_count_reg.sv
module lbc_count_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         dec_en,
  output logic [W-1:0] eff
);
  logic [W-1:0] q;

  // a load bypasses the register so a same-cycle branch sees it
  assign eff = load_en ? load_val : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (dec_en) q <= eff - W'(1);
    else q <= eff;
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |-> eff != '0); // R3
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> q == $past(eff) - W'(1)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_en && !load_en) |=> $stable(q)); // R10
endmodule

// File: rtl/lbc_decide.sv
module lbc_decide
  import lbc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DRN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  br_kind_t         kind,
  input  logic [CNT_W-1:0] iter_cnt,
  input  logic [DRN_W-1:0] drain_cnt,
  output logic             taken,
  output logic             rotate,
  output logic             pred,
  output logic             iter_dec,
  output logic             drain_dec
);
  logic iter_nz, drain_nz, drain_more;

  assign iter_nz = iter_cnt != '0;
  assign drain_nz = drain_cnt != '0;
  assign drain_more = drain_cnt > DRN_W'(1);

  always_comb begin
    taken = 1'b0;
    rotate = 1'b0;
    pred = 1'b0;
    iter_dec = 1'b0;
    drain_dec = 1'b0;
    if (strobe) begin
      if (kind == BR_COUNTED) begin
        taken = iter_nz;
        iter_dec = iter_nz;
      end else if (iter_nz) begin
        taken = 1'b1;
        rotate = 1'b1;
        pred = 1'b1;
        iter_dec = 1'b1;
      end else if (drain_nz) begin
        rotate = 1'b1;
        drain_dec = 1'b1;
        taken = drain_more;
      end
    end
  end

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> !(taken || rotate || pred)); // R10
  AST_COUNTED_NO_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && kind == BR_COUNTED) |-> !rotate && !drain_dec); // R11
  AST_PRED_WITH_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    pred |-> rotate && taken); // R4
  AST_EXIT_ZERO_PRED: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && !taken) |-> !pred); // R6
endmodule

// File: rtl/loop_branch_ctrl.sv
module loop_branch_ctrl
  import lbc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DRN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_strobe,
  input  logic             br_kind,
  input  logic             iter_load,
  input  logic [CNT_W-1:0] iter_value,
  input  logic             drain_load,
  input  logic [DRN_W-1:0] drain_value,
  output logic             taken,
  output logic             rotate,
  output logic             stage1_pred
);
  logic [CNT_W-1:0] iter_eff;
  logic [DRN_W-1:0] drain_eff;
  logic             iter_dec, drain_dec;

  lbc_count_reg #(.W(CNT_W)) u_iter (
    .clk(clk), .rst_n(rst_n), .load_en(iter_load), .load_val(iter_value),
    .dec_en(iter_dec), .eff(iter_eff)
  );

  lbc_count_reg #(.W(DRN_W)) u_drain (
    .clk(clk), .rst_n(rst_n), .load_en(drain_load), .load_val(drain_value),
    .dec_en(drain_dec), .eff(drain_eff)
  );

  lbc_decide #(.CNT_W(CNT_W), .DRN_W(DRN_W)) u_decide (
    .clk(clk), .rst_n(rst_n), .strobe(br_strobe), .kind(br_kind_t'(br_kind)),
    .iter_cnt(iter_eff), .drain_cnt(drain_eff),
    .taken(taken), .rotate(rotate), .pred(stage1_pred),
    .iter_dec(iter_dec), .drain_dec(drain_dec)
  );

  AST_FALL_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (br_strobe && br_kind && rotate && !taken && !drain_load && !iter_load)
    |=> !(br_strobe && br_kind && !iter_load && !drain_load) || !rotate); // R6
endmodule

// File: tb/tb_loop_branch_ctrl.sv
`timescale 1ns/1ps
module tb_loop_branch_ctrl;
  localparam int CNT_W = 32;
  localparam int DRN_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic br_strobe = 1'b0, br_kind = 1'b0, iter_load = 1'b0, drain_load = 1'b0;
  logic [CNT_W-1:0] iter_value = '0;
  logic [DRN_W-1:0] drain_value = '0;
  logic taken, rotate, stage1_pred;
  logic s_tk, s_rot, s_pr;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  loop_branch_ctrl #(.CNT_W(CNT_W), .DRN_W(DRN_W)) dut (
    .clk(clk), .rst_n(rst_n), .br_strobe(br_strobe), .br_kind(br_kind),
    .iter_load(iter_load), .iter_value(iter_value),
    .drain_load(drain_load), .drain_value(drain_value),
    .taken(taken), .rotate(rotate), .stage1_pred(stage1_pred)
  );

  task automatic step(input logic s, input logic k, input logic il,
                      input int iv, input logic dl, input int dv);
    br_strobe = s; br_kind = k; iter_load = il; iter_value = CNT_W'(iv);
    drain_load = dl; drain_value = DRN_W'(dv);
    #1;
    s_tk = taken; s_rot = rotate; s_pr = stage1_pred;
    @(posedge clk);
    @(negedge clk);
    br_strobe = 0; iter_load = 0; drain_load = 0;
  endtask

  task automatic chk(input string req, input logic tk, input logic rot, input logic pr);
    checks++;
    if ({s_tk, s_rot, s_pr} !== {tk, rot, pr}) begin
      fails++;
      $display("FAIL %s: taken/rotate/pred got %b%b%b expected %b%b%b",
               req, s_tk, s_rot, s_pr, tk, rot, pr);
    end
  endtask

  task automatic t_reset();
    step(0, 0, 0, 0, 0, 0); chk("R10", 0, 0, 0);
    step(1, 1, 0, 0, 0, 0); chk("R1", 0, 0, 0);
    step(1, 1, 0, 0, 0, 0); chk("R7", 0, 0, 0);
  endtask

  task automatic t_counted();
    step(0, 0, 1, 2, 1, 2);
    step(1, 0, 0, 0, 0, 0); chk("R2", 1, 0, 0);
    step(0, 0, 0, 0, 0, 0); chk("R10", 0, 0, 0);
    step(1, 0, 0, 0, 0, 0); chk("R2", 1, 0, 0);
    step(1, 0, 0, 0, 0, 0); chk("R3", 0, 0, 0);
    step(1, 0, 0, 0, 0, 0); chk("R3", 0, 0, 0);
    // drain count still 2 after counted branches
    step(1, 1, 0, 0, 0, 0); chk("R11", 1, 1, 0);
    step(1, 1, 0, 0, 0, 0); chk("R6", 0, 1, 0);
    step(1, 1, 0, 0, 0, 0); chk("R7", 0, 0, 0);
  endtask

  task automatic t_pipelined();
    step(0, 0, 1, 1, 1, 3);
    step(1, 1, 0, 0, 0, 0); chk("R4", 1, 1, 1);
    step(1, 1, 0, 0, 0, 0); chk("R5", 1, 1, 0);
    step(1, 1, 0, 0, 0, 0); chk("R5", 1, 1, 0);
    step(1, 1, 0, 0, 0, 0); chk("R6", 0, 1, 0);
    step(1, 1, 0, 0, 0, 0); chk("R7", 0, 0, 0);
  endtask

  task automatic t_load_priority();
    step(0, 0, 1, 5, 0, 0);
    step(1, 0, 1, 0, 0, 0); chk("R8", 0, 0, 0);
    step(1, 0, 1, 3, 0, 0); chk("R8", 1, 0, 0);
    step(1, 0, 0, 0, 0, 0); chk("R8", 1, 0, 0);
    step(1, 0, 0, 0, 0, 0); chk("R8", 1, 0, 0);
    step(1, 0, 0, 0, 0, 0); chk("R8", 0, 0, 0);
    step(1, 1, 0, 0, 1, 1); chk("R8", 0, 1, 0);
  endtask

  task automatic t_copy_loop();
    int n_taken = 0, n_rot = 0, n_one = 0;
    logic done = 0;
    step(0, 0, 1, 127, 1, 4);
    for (int i = 0; i < 200 && !done; i++) begin
      step(1, 1, 0, 0, 0, 0);
      if (s_rot) n_rot++;
      if (s_pr) n_one++;
      if (s_tk) n_taken++; else done = 1;
    end
    checks++;
    if (n_taken != 130) begin fails++; $display("FAIL R9: taken %0d expected 130", n_taken); end
    checks++;
    if (n_rot != 131) begin fails++; $display("FAIL R9: rotations %0d expected 131", n_rot); end
    checks++;
    if (n_one != 127) begin fails++; $display("FAIL R4: ones fed %0d expected 127", n_one); end
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_counted();
    t_pipelined();
    t_load_priority();
    t_copy_loop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule